// File: doc/BRIEF.md
# Dual-Processor Mailbox Register Bank

This block is a small shared register bank that lets an 8-bit controller and a 16-bit signal processor pass data to each other. It holds sixteen bytes, split into two halves by direction: the lower eight bytes carry messages from the controller to the signal processor, and the upper eight bytes carry messages the other way. The controller reaches every byte through a byte-wide port with a 4-bit address. The signal processor sees the same storage as eight 16-bit words through a word-wide port.

Each pair of neighbouring bytes forms one signal-processor word, and the byte at the even address is the high half of that word. The signal processor can write only the four words of its own outgoing half, and it always writes a whole word in one clock edge. The controller can read and write any of the sixteen bytes. Reads on both ports are combinational from the stored state. A write takes effect at the next rising clock edge.

The reset input clears the bank at once. Its release is synchronised to the clock, so writes have effect only from the third rising edge after the reset input goes high.

Top module: `mbox_bank`

## Requirements
- R1: Controller addresses 0x0..0x7 form the controller-to-processor half. A controller byte written there is visible on `d_rdata` when `d_addr` is 0..3, where the word index equals `c_addr[2:1]`.
- R2: Controller addresses 0x8..0xF form the processor-to-controller half. A processor write with `d_we`=1 and `d_addr[2]`=1 stores `d_wdata` into word `d_addr[1:0]` of this half, and the controller reads it at bytes 0x8+2*`d_addr[1:0]` and the following address.
- R3: In every word, the byte at the even controller address is bits 15:8 and the byte at the odd address is bits 7:0.
- R4: The controller can write and read back all sixteen byte locations. `c_rdata` always shows the byte at `c_addr`, and a write with `c_we`=1 is visible from the next rising edge.
- R5: A processor word write updates both bytes at the same rising edge, so no read ever shows one new byte next to one old byte.
- R6: A processor write with `d_addr[2]`=0 (the controller-to-processor half) leaves every stored byte unchanged.
- R7: When the controller and the processor write the same word at the same edge, the processor data is stored in both bytes. A controller write to a different word at the same edge still takes effect.
- R8: While `rst_n` is low, every stored byte reads as zero. After `rst_n` rises, writes take effect from the third rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| c_addr | input | 4 | Controller byte address; bit 3 selects the processor-to-controller half |
| c_we | input | 1 | Controller write strobe |
| c_wdata | input | 8 | Controller write byte |
| c_rdata | output | 8 | Byte stored at `c_addr` |
| d_addr | input | 3 | Processor word address; bit 2 selects the processor-to-controller half |
| d_we | input | 1 | Processor write strobe; has an effect only when bit 2 of `d_addr` is 1 |
| d_wdata | input | 16 | Processor write word |
| d_rdata | output | 16 | Word stored at `d_addr` |

## Verification
A controller byte write and a processor word write can fall on the same rising edge. The overlap matters most when both target the same word in the processor-to-controller half. The bench drives both strobes in one cycle, first on the same word and then on different words. It then reads both bytes of each affected word from the controller side and the whole word from the processor side. Pass means the overlapping word holds only the processor data and the non-overlapping controller byte holds its new value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Default geometry of the mailbox
  localparam int unsigned MB_BYTE_W  = 8;  // controller data width
  localparam int unsigned MB_NWORDS  = 4;  // words per direction
endpackage

// File: rtl/mbox_slot.sv
// One word-wide mailbox register: two controller byte lanes plus an
// optional whole-word processor write that takes priority.
module mbox_slot #(
  parameter int unsigned BW     = 8,
  parameter bit          DSP_WR = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            c_we_hi,
  input  logic            c_we_lo,
  input  logic [BW-1:0]   c_wdata,
  input  logic            d_we,
  input  logic [2*BW-1:0] d_wdata,
  output logic [2*BW-1:0] q
);
  logic [2*BW-1:0] q_nxt;
  logic            q_en;

  always_comb begin
    q_nxt = q;
    if (c_we_hi) q_nxt[2*BW-1:BW] = c_wdata;
    if (c_we_lo) q_nxt[BW-1:0]    = c_wdata;
    if (DSP_WR && d_we) q_nxt     = d_wdata;   // processor write wins
    q_en = c_we_hi | c_we_lo | (DSP_WR & d_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/mbox_crd.sv
// Controller-side byte read multiplexer.
module mbox_crd #(
  parameter int unsigned BW  = 8,
  parameter int unsigned NS  = 8,
  localparam int unsigned AW = $clog2(NS) + 1
) (
  input  logic [NS-1:0][2*BW-1:0] words,
  input  logic [AW-1:0]           addr,
  output logic [BW-1:0]           rdata
);
  logic [2*BW-1:0] sel;
  always_comb begin
    sel   = words[addr[AW-1:1]];
    rdata = addr[0] ? sel[BW-1:0] : sel[2*BW-1:BW];
  end
endmodule

// File: rtl/mbox_drd.sv
// Processor-side word read multiplexer.
module mbox_drd #(
  parameter int unsigned BW  = 8,
  parameter int unsigned NS  = 8,
  localparam int unsigned AW = $clog2(NS)
) (
  input  logic [NS-1:0][2*BW-1:0] words,
  input  logic [AW-1:0]           addr,
  output logic [2*BW-1:0]         rdata
);
  always_comb rdata = words[addr];
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned BW   = MB_BYTE_W,
  parameter int unsigned NW   = MB_NWORDS,
  localparam int unsigned NS  = 2 * NW,
  localparam int unsigned DAW = $clog2(NS),
  localparam int unsigned CAW = DAW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CAW-1:0]  c_addr,
  input  logic            c_we,
  input  logic [BW-1:0]   c_wdata,
  output logic [BW-1:0]   c_rdata,
  input  logic [DAW-1:0]  d_addr,
  input  logic            d_we,
  input  logic [2*BW-1:0] d_wdata,
  output logic [2*BW-1:0] d_rdata
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  logic [NS-1:0][2*BW-1:0] words;

  // Slots 0..NW-1: controller to processor; NW..NS-1: processor to controller
  for (genvar g = 0; g < NS; g++) begin : g_slot
    localparam logic [DAW-1:0] IDX = DAW'(g);
    localparam bit             INB = (g >= NW);
    logic hit_c, we_hi, we_lo, we_d;

    always_comb begin
      hit_c = c_we & (c_addr[CAW-1:1] == IDX);
      we_hi = hit_c & ~c_addr[0];
      we_lo = hit_c &  c_addr[0];
      we_d  = d_we & d_addr[DAW-1] & (d_addr == IDX);
    end

    mbox_slot #(.BW(BW), .DSP_WR(INB)) u_slot (
      .clk     (clk),
      .rst_n   (srst_n),
      .c_we_hi (we_hi),
      .c_we_lo (we_lo),
      .c_wdata (c_wdata),
      .d_we    (we_d),
      .d_wdata (d_wdata),
      .q       (words[g])
    );
  end

  mbox_crd #(.BW(BW), .NS(NS)) u_crd (
    .words (words),
    .addr  (c_addr),
    .rdata (c_rdata)
  );

  mbox_drd #(.BW(BW), .NS(NS)) u_drd (
    .words (words),
    .addr  (d_addr),
    .rdata (d_rdata)
  );
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int unsigned BW  = 8,
  parameter int unsigned NW  = 4,
  localparam int unsigned NS  = 2 * NW,
  localparam int unsigned DAW = $clog2(NS),
  localparam int unsigned CAW = DAW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            srst_n,
  input logic [CAW-1:0]  c_addr,
  input logic            c_we,
  input logic [BW-1:0]   c_wdata,
  input logic [BW-1:0]   c_rdata,
  input logic [DAW-1:0]  d_addr,
  input logic            d_we,
  input logic [2*BW-1:0] d_wdata,
  input logic [2*BW-1:0] d_rdata
);
  logic c_hits_dwr;
  assign c_hits_dwr = d_we & d_addr[DAW-1] & (d_addr == c_addr[CAW-1:1]);

  // R8: reset clears everything visible on both ports
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_zero: assert (c_rdata == '0 && d_rdata == '0)
        else $error("R8 reset state not zero");
    end
  end

  // R4: a controller write is read back next cycle unless the processor overrode it
  a_r4_ctrl_readback: assert property (@(posedge clk) disable iff (!srst_n)
    (c_we && !c_hits_dwr) |=> (($past(c_addr) != c_addr) || (c_rdata == $past(c_wdata))));

  // R2 / R5 / R7: a processor word write lands whole
  a_r5_dsp_whole_word: assert property (@(posedge clk) disable iff (!srst_n)
    (d_we && d_addr[DAW-1]) |=> (($past(d_addr) != d_addr) || (d_rdata == $past(d_wdata))));

  // R6: processor write to the controller-to-processor half changes nothing
  a_r6_out_ignored: assert property (@(posedge clk) disable iff (!srst_n)
    (d_we && !d_addr[DAW-1] && !c_we) |=> (($past(d_addr) != d_addr) || $stable(d_rdata)));

  // R1 / R3: both ports agree on byte placement
  a_r3_byte_order: assert property (@(posedge clk) disable iff (!srst_n)
    (d_addr == c_addr[CAW-1:1]) |->
      (c_rdata == (c_addr[0] ? d_rdata[BW-1:0] : d_rdata[2*BW-1:BW])));
endmodule

bind mbox_bank mbox_bank_chk #(.BW(BW), .NW(NW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .srst_n  (srst_n),
  .c_addr  (c_addr),
  .c_we    (c_we),
  .c_wdata (c_wdata),
  .c_rdata (c_rdata),
  .d_addr  (d_addr),
  .d_we    (d_we),
  .d_wdata (d_wdata),
  .d_rdata (d_rdata)
);

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  c_addr;
  logic        c_we;
  logic [7:0]  c_wdata;
  logic [7:0]  c_rdata;
  logic [2:0]  d_addr;
  logic        d_we;
  logic [15:0] d_wdata;
  logic [15:0] d_rdata;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  mbox_bank uut (
    .clk(clk), .rst_n(rst_n),
    .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .d_addr(d_addr), .d_we(d_we), .d_wdata(d_wdata), .d_rdata(d_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    c_we = 1'b0; d_we = 1'b0;
  endtask

  // one controller byte write, returns after the edge at a falling edge
  task automatic cwr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); c_addr = a; c_wdata = v; c_we = 1'b1;
    @(negedge clk); c_we = 1'b0;
  endtask

  task automatic dwr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); d_addr = a; d_wdata = v; d_we = 1'b1;
    @(negedge clk); d_we = 1'b0;
  endtask

  task automatic crd(input logic [3:0] a, output logic [7:0] v);
    c_addr = a; #0.5; v = c_rdata;
  endtask

  task automatic drd(input logic [2:0] a, output logic [15:0] v);
    d_addr = a; #0.5; v = d_rdata;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [15:0] w;
    cwr(4'h3, 8'hA5);
    dwr(3'd6, 16'hC3C3);
    @(negedge clk); rst_n = 1'b0; #0.5;
    crd(4'h3, b);  chk("R8 byte 3 cleared", {8'h0, b}, 16'h0000);
    drd(3'd6, w);  chk("R8 word 6 cleared", w, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    // write on first edge after release must not stick
    c_addr = 4'h2; c_wdata = 8'h11; c_we = 1'b1;
    @(negedge clk); c_we = 1'b0;
    crd(4'h2, b);  chk("R8 write during release ignored", {8'h0, b}, 16'h0000);
    @(negedge clk);
    cwr(4'h2, 8'h22);
    crd(4'h2, b);  chk("R8 write after release", {8'h0, b}, 16'h0022);
  endtask

  task automatic t_ctrl_out();
    logic [15:0] w;
    for (int i = 0; i < 8; i++) cwr(4'(i), 8'(8'h10 + 8'(i) * 8'h11));
    for (int k = 0; k < 4; k++) begin
      drd(3'(k), w);
      chk("R1 R3 outgoing word", w,
          {8'(8'h10 + 8'(2*k) * 8'h11), 8'(8'h10 + 8'(2*k+1) * 8'h11)});
    end
  endtask

  task automatic t_dsp_in();
    logic [7:0] hi, lo;
    for (int k = 0; k < 4; k++) dwr(3'(4 + k), 16'(16'hA000 + 16'(k) * 16'h0111));
    for (int k = 0; k < 4; k++) begin
      crd(4'(8 + 2*k), hi);
      crd(4'(9 + 2*k), lo);
      chk("R2 R3 incoming word via bytes", {hi, lo}, 16'(16'hA000 + 16'(k) * 16'h0111));
    end
  endtask

  task automatic t_ctrl_all();
    logic [7:0] b;
    for (int i = 0; i < 16; i++) cwr(4'(i), 8'(8'hF0 ^ 8'(i * 7)));
    for (int i = 0; i < 16; i++) begin
      crd(4'(i), b);
      chk("R4 controller readback", {8'h0, b}, {8'h0, 8'(8'hF0 ^ 8'(i * 7))});
    end
  endtask

  task automatic t_torn();
    logic [7:0] hi, lo; logic [15:0] w;
    dwr(3'd7, 16'h1111);
    @(negedge clk); d_addr = 3'd7; d_wdata = 16'h9E5A; d_we = 1'b1;
    c_addr = 4'hE; #0.5; hi = c_rdata;
    chk("R5 old high byte before edge", {8'h0, hi}, 16'h0011);
    @(negedge clk); d_we = 1'b0;
    crd(4'hE, hi); crd(4'hF, lo);
    chk("R5 both bytes after one edge", {hi, lo}, 16'h9E5A);
    drd(3'd7, w);  chk("R5 word view", w, 16'h9E5A);
  endtask

  task automatic t_out_ignored();
    logic [15:0] w;
    cwr(4'h4, 8'h3C); cwr(4'h5, 8'hC3);
    dwr(3'd2, 16'hFFFF);
    drd(3'd2, w);  chk("R6 processor write to outgoing ignored", w, 16'h3CC3);
  endtask

  task automatic t_collide();
    logic [7:0] hi, lo, b;
    @(negedge clk);
    c_addr = 4'hA; c_wdata = 8'h55; c_we = 1'b1;
    d_addr = 3'd5; d_wdata = 16'h1234; d_we = 1'b1;
    @(negedge clk); idle();
    crd(4'hA, hi); crd(4'hB, lo);
    chk("R7 same word processor wins", {hi, lo}, 16'h1234);
    @(negedge clk);
    c_addr = 4'h8; c_wdata = 8'h77; c_we = 1'b1;
    d_addr = 3'd6; d_wdata = 16'hBEEF; d_we = 1'b1;
    @(negedge clk); idle();
    crd(4'h8, b);  chk("R7 other word controller write kept", {8'h0, b}, 16'h0077);
    crd(4'hC, hi); crd(4'hD, lo);
    chk("R7 other word processor write kept", {hi, lo}, 16'hBEEF);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    c_addr = '0; c_wdata = '0; d_addr = '0; d_wdata = '0;
    do_reset();
    begin
      logic [7:0] b; logic [15:0] w;
      crd(4'h0, b); chk("R8 initial byte zero", {8'h0, b}, 16'h0000);
      drd(3'd4, w); chk("R8 initial word zero", w, 16'h0000);
    end
    t_ctrl_out();
    t_dsp_in();
    t_ctrl_all();
    t_torn();
    t_out_ignored();
    t_collide();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule